// File: doc/BRIEF.md
# Wide Multiply and Divide Execution Unit

This block is the product, quotient and remainder unit of a 64-bit register machine. Each request arrives as a one-cycle start strobe. The strobe comes with an 8-bit opcode, a destination operand, a source register operand and a 32-bit immediate. The unit returns a 64-bit result and a single-cycle done strobe. When a request cannot complete, it instead reports one of three conditions: a zero divisor, signed division overflow, or an opcode it does not implement.

Multiplication finishes in one cycle from a full double-width product. The unit supplies the low half of a product, and also the high half of both the unsigned and the signed 64x64 product. Division and remainder run on a shared restoring shift-subtract engine. The engine spends one cycle per quotient bit, so a 32-bit operation takes 32 steps and a 64-bit operation takes 64 steps. Every 32-bit operation reads only the low halves of its operands and returns its result zero-extended.

Top module: `wide_muldiv`

## Requirements
- R1: An opcode is in the family only when its bits 2:0 are 110. In a family opcode, bit 3 set takes the second operand from `src_opnd`. Bit 3 clear takes the second operand from `imm_opnd`, sign-extended to 64 bits.
- R2: Upper nibble 0x3 returns bits 127:64 of the unsigned 128-bit product. Upper nibble 0xB returns bits 127:64 of the two's-complement 128-bit product.
- R3: Upper nibble 0x8 returns the low 32 bits of the product, and 0x9 returns the low 64 bits. The result is the same for signed and unsigned readings of the operands.
- R4: Every 32-bit operation (upper nibble 0x4, 0x6, 0x8, 0xC or 0xE) uses only bits 31:0 of both operands and returns zeros in bits 63:32.
- R5: Upper nibbles 0x4 and 0x5 return the unsigned quotient at 32 and 64 bits. Upper nibbles 0x6 and 0x7 return the unsigned remainder at 32 and 64 bits.
- R6: Upper nibbles 0xC and 0xD return the signed quotient at 32 and 64 bits, truncated toward zero. Upper nibbles 0xE and 0xF return the signed remainder at 32 and 64 bits. The remainder carries the sign of the dividend.
- R7: For a divide or remainder whose divisor is zero at the operation width, `div_zero` is raised together with done and `result` is left unchanged.
- R8: For a signed divide or remainder, consider a dividend equal to the most negative value of the width together with a divisor of all ones at that width. This raises `div_ovf` together with done and leaves `result` unchanged.
- R9: An opcode with upper nibble 0x0, 0x1, 0x2 or 0xA, or with bits 2:0 not equal to 110, raises `illegal` together with done and leaves `result` unchanged.
- R10: Done is high for exactly one cycle. Multiplies, exceptions and illegal opcodes raise it after the clock edge that accepts start. A division raises it 32 (32-bit) or 64 (64-bit) edges after that. The flags are high only together with done, and at most one is high.
- R11: A start pulse that arrives while a division is in progress is ignored.
- R12: After reset, `result` is zero and done and all flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, one cycle |
| opcode | input | 8 | Operation code |
| dst_opnd | input | 64 | First operand (multiplicand or dividend) |
| src_opnd | input | 64 | Register second operand |
| imm_opnd | input | 32 | Immediate second operand, sign-extended |
| result | output | 64 | Last written result |
| done | output | 1 | Completion strobe |
| div_zero | output | 1 | Zero divisor, valid with done |
| div_ovf | output | 1 | Signed overflow, valid with done, holds with done |
| illegal | output | 1 | Opcode outside the family, valid with done |

## Verification
Count from the clock edge that captures start. The result and done of a multiply, and every exception or illegal report, are due at that same edge. A 32-bit division is due 32 edges later and a 64-bit division 64 edges later. For each request, the bench counts falling edges from the start edge until done appears, and compares that count with 1, 33 or 65. It then reads the result and flags at that falling edge, and confirms one falling edge later that done has dropped. For a request that is ignored, the bench waits past the point where a second completion could appear and confirms that none arrives.

// File: rtl/wmd_pkg.sv
package wmd_pkg;
   localparam int OPC_W = 8;

   typedef enum logic [2:0] {
      K_MULHU,
      K_MULHS,
      K_MULLO,
      K_DIV,
      K_REM
   } op_kind_e;

   typedef struct packed {
      logic     legal;
      op_kind_e kind;
      logic     sgn;
      logic     is32;
      logic     use_reg;
   } op_dec_t;
endpackage

// File: rtl/wmd_decode.sv
module wmd_decode
   import wmd_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output op_dec_t          dec
);
   logic [3:0] nib;
   logic       shape_ok;
   logic       known;

   assign nib      = opcode[7:4];
   assign shape_ok = (opcode[2:0] == 3'b110);

   always_comb begin
      dec         = '0;
      dec.kind    = K_MULLO;
      dec.use_reg = opcode[3];
      dec.is32    = ~nib[0];
      dec.sgn     = nib[3];
      known       = 1'b1;
      case (nib)
         4'h3:                      dec.kind = K_MULHU;
         4'hB:                      dec.kind = K_MULHS;
         4'h8, 4'h9:                dec.kind = K_MULLO;
         4'h4, 4'h5, 4'hC, 4'hD:    dec.kind = K_DIV;
         4'h6, 4'h7, 4'hE, 4'hF:    dec.kind = K_REM;
         default:                   known    = 1'b0;
      endcase
      dec.legal = shape_ok & known;
   end
endmodule

// File: rtl/wmd_mul.sv
module wmd_mul
   import wmd_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter bit HI_SIGN_FIX = 1'b1
)(
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  op_kind_e        kind,
   input  logic            is32,
   output logic [XLEN-1:0] res
);
   localparam int HALF = XLEN / 2;
   localparam int PW   = 2 * XLEN;

   logic [PW-1:0]   prod_u;
   logic [XLEN-1:0] hi_s;

   assign prod_u = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};

   generate
      if (HI_SIGN_FIX) begin : g_fix
         // signed high half from the unsigned product plus two corrections
         logic [XLEN-1:0] corr_a, corr_b;
         assign corr_a = a[XLEN-1] ? b : '0;
         assign corr_b = b[XLEN-1] ? a : '0;
         assign hi_s   = prod_u[PW-1:XLEN] - corr_a - corr_b;
      end else begin : g_direct
         logic signed [PW-1:0] prod_s;
         assign prod_s = $signed({{XLEN{a[XLEN-1]}}, a}) * $signed({{XLEN{b[XLEN-1]}}, b});
         assign hi_s   = prod_s[PW-1:XLEN];
      end
   endgenerate

   always_comb begin
      case (kind)
         K_MULHU: res = prod_u[PW-1:XLEN];
         K_MULHS: res = hi_s;
         default: res = is32 ? {{HALF{1'b0}}, prod_u[HALF-1:0]} : prod_u[XLEN-1:0];
      endcase
   end
endmodule

// File: rtl/wmd_div.sv
module wmd_div #(
   parameter int XLEN = 64
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            is32,
   input  logic            sgn,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            busy,
   output logic            last,
   output logic [XLEN-1:0] quo,
   output logic [XLEN-1:0] rem
);
   localparam int HALF = XLEN / 2;
   localparam int CW   = $clog2(XLEN + 1);
   localparam logic [XLEN-1:0] ONE = 1;

   generate
      if (XLEN % 2 != 0 || XLEN < 8) begin : g_bad_w
         $error("wmd_div: XLEN must be even and at least 8");
      end
   endgenerate

   logic [XLEN-1:0] rem_r, quo_r, dvs_r;
   logic [CW-1:0]   cnt_r;
   logic            busy_r, qneg_r, rneg_r, is32_r;

   // operand preparation at load
   logic [XLEN-1:0] mask_in, a_w, b_w, mag_a, mag_b;
   logic            sa, sb;

   assign mask_in = is32 ? {{HALF{1'b0}}, {HALF{1'b1}}} : '1;
   assign a_w     = a & mask_in;
   assign b_w     = b & mask_in;
   assign sa      = sgn & (is32 ? a[HALF-1] : a[XLEN-1]);
   assign sb      = sgn & (is32 ? b[HALF-1] : b[XLEN-1]);
   assign mag_a   = sa ? ((~a_w + ONE) & mask_in) : a_w;
   assign mag_b   = sb ? ((~b_w + ONE) & mask_in) : b_w;

   // one restoring step
   logic [XLEN:0]   shifted, diff;
   logic            qbit;
   logic [XLEN-1:0] rem_n, quo_n, mask_r;

   assign shifted = {rem_r, quo_r[XLEN-1]};
   assign diff    = shifted - {1'b0, dvs_r};
   assign qbit    = ~diff[XLEN];
   assign rem_n   = qbit ? diff[XLEN-1:0] : shifted[XLEN-1:0];
   assign quo_n   = {quo_r[XLEN-2:0], qbit};
   assign mask_r  = is32_r ? {{HALF{1'b0}}, {HALF{1'b1}}} : '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_r  <= '0;
         quo_r  <= '0;
         dvs_r  <= '0;
         cnt_r  <= '0;
         busy_r <= 1'b0;
         qneg_r <= 1'b0;
         rneg_r <= 1'b0;
         is32_r <= 1'b0;
      end else if (go) begin
         rem_r  <= '0;
         quo_r  <= is32 ? (mag_a << HALF) : mag_a;
         dvs_r  <= mag_b;
         cnt_r  <= is32 ? CW'(HALF) : CW'(XLEN);
         busy_r <= 1'b1;
         qneg_r <= sa ^ sb;
         rneg_r <= sa;
         is32_r <= is32;
      end else if (busy_r) begin
         rem_r <= rem_n;
         quo_r <= quo_n;
         cnt_r <= cnt_r - CW'(1);
         if (cnt_r == CW'(1)) busy_r <= 1'b0;
      end
   end

   assign busy = busy_r;
   assign last = busy_r && (cnt_r == CW'(1));
   assign quo  = qneg_r ? ((~quo_n + ONE) & mask_r) : quo_n;
   assign rem  = rneg_r ? ((~rem_n + ONE) & mask_r) : rem_n;

   // R5
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_r |-> (rem_r < dvs_r));

   // R10
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_r |-> (cnt_r != '0 && cnt_r <= CW'(XLEN)));
endmodule

// File: rtl/wide_muldiv.sv
module wide_muldiv
   import wmd_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int IMM_W       = 32,
   parameter bit HI_SIGN_FIX = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       opcode,
   input  logic [XLEN-1:0]  dst_opnd,
   input  logic [XLEN-1:0]  src_opnd,
   input  logic [IMM_W-1:0] imm_opnd,
   output logic [XLEN-1:0]  result,
   output logic             done,
   output logic             div_zero,
   output logic             div_ovf,
   output logic             illegal
);
   localparam int HALF = XLEN / 2;
   localparam logic [XLEN-1:0] MIN_F = {1'b1, {(XLEN-1){1'b0}}};
   localparam logic [HALF-1:0] MIN_H = {1'b1, {(HALF-1){1'b0}}};

   generate
      if (IMM_W >= XLEN || IMM_W < 1) begin : g_bad_imm
         $error("wide_muldiv: IMM_W must lie in 1..XLEN-1");
      end
      if (OPC_W != 8) begin : g_bad_opc
         $error("wide_muldiv: opcode layout assumes 8 bits");
      end
   endgenerate

   op_dec_t         dec;
   logic [XLEN-1:0] imm_ext, opnd_b, mul_res, eng_quo, eng_rem;
   logic            is_div, dz, ovf, accept, go, eng_busy, eng_last;
   logic            is32_q, rem_q;

   wmd_decode u_dec (
      .opcode (opcode),
      .dec    (dec)
   );

   assign imm_ext = {{(XLEN-IMM_W){imm_opnd[IMM_W-1]}}, imm_opnd};
   assign opnd_b  = dec.use_reg ? src_opnd : imm_ext;
   assign is_div  = (dec.kind == K_DIV) || (dec.kind == K_REM);

   assign dz  = dec.is32 ? (opnd_b[HALF-1:0] == '0) : (opnd_b == '0);
   assign ovf = dec.sgn & (dec.is32
                ? (dst_opnd[HALF-1:0] == MIN_H && opnd_b[HALF-1:0] == '1)
                : (dst_opnd == MIN_F && opnd_b == '1));

   assign accept = start & ~eng_busy;
   assign go     = accept & dec.legal & is_div & ~dz & ~ovf;

   wmd_mul #(
      .XLEN        (XLEN),
      .HI_SIGN_FIX (HI_SIGN_FIX)
   ) u_mul (
      .a    (dst_opnd),
      .b    (opnd_b),
      .kind (dec.kind),
      .is32 (dec.is32),
      .res  (mul_res)
   );

   wmd_div #(
      .XLEN (XLEN)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .is32  (dec.is32),
      .sgn   (dec.sgn),
      .a     (dst_opnd),
      .b     (opnd_b),
      .busy  (eng_busy),
      .last  (eng_last),
      .quo   (eng_quo),
      .rem   (eng_rem)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result   <= '0;
         done     <= 1'b0;
         div_zero <= 1'b0;
         div_ovf  <= 1'b0;
         illegal  <= 1'b0;
         is32_q   <= 1'b0;
         rem_q    <= 1'b0;
      end else begin
         done     <= 1'b0;
         div_zero <= 1'b0;
         div_ovf  <= 1'b0;
         illegal  <= 1'b0;
         if (eng_last) begin
            result <= rem_q ? eng_rem : eng_quo;
            done   <= 1'b1;
         end else if (accept) begin
            if (!dec.legal) begin
               done    <= 1'b1;
               illegal <= 1'b1;
            end else begin
               is32_q <= dec.is32;
               rem_q  <= (dec.kind == K_REM);
               if (is_div) begin
                  if (dz) begin
                     done     <= 1'b1;
                     div_zero <= 1'b1;
                  end else if (ovf) begin
                     done    <= 1'b1;
                     div_ovf <= 1'b1;
                  end
               end else begin
                  result <= mul_res;
                  done   <= 1'b1;
               end
            end
         end
      end
   end

   // R4
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_zero && !div_ovf && !illegal && is32_q) |-> (result[XLEN-1:HALF] == '0));

   // R7
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_zero |-> (result == $past(result)));

   // R8
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_ovf |-> (result == $past(result)));

   // R9
   ill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (result == $past(result)));

   // R10
   flag_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_zero || div_ovf || illegal) |-> done);

   // R10
   one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({div_zero, div_ovf, illegal}));

   // R11
   busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && !eng_last) |=> !done);
endmodule

// File: tb/wide_muldiv_test.sv
module wide_muldiv_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = '0;
   logic [63:0] dst_opnd = '0;
   logic [63:0] src_opnd = '0;
   logic [31:0] imm_opnd = '0;
   logic [63:0] result;
   logic        done, div_zero, div_ovf, illegal;

   int          vectors = 0;
   int          miscompares = 0;
   logic [63:0] last_res = '0;

   always #5 clk = ~clk;

   wide_muldiv uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .opcode   (opcode),
      .dst_opnd (dst_opnd),
      .src_opnd (src_opnd),
      .imm_opnd (imm_opnd),
      .result   (result),
      .done     (done),
      .div_zero (div_zero),
      .div_ovf  (div_ovf),
      .illegal  (illegal)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // independent reference: returns {illegal, zero, ovf, value}
   function automatic logic [66:0] model(input logic [7:0] op, input logic [63:0] a,
                                         input logic [63:0] b);
      logic [3:0]          n;
      logic                il, z, o, w32;
      logic [63:0]         r;
      logic [127:0]        pu;
      logic signed [127:0] ps;
      logic [31:0]         t32;
      int                  sa, sb;
      longint              la, lb;
      n = op[7:4]; w32 = ~n[0];
      il = 1'b0; z = 1'b0; o = 1'b0; r = '0;
      if (op[2:0] != 3'b110 || n == 4'h0 || n == 4'h1 || n == 4'h2 || n == 4'hA) il = 1'b1;
      else if (n == 4'h3) begin
         pu = {64'b0, a} * {64'b0, b};
         r  = pu[127:64];
      end else if (n == 4'hB) begin
         ps = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
         r  = ps[127:64];
      end else if (n == 4'h8) begin
         t32 = a[31:0] * b[31:0];
         r   = {32'b0, t32};
      end else if (n == 4'h9) begin
         r = a * b;
      end else begin
         z = w32 ? (b[31:0] == 0) : (b == 0);
         if (!z && n[3]) o = w32 ? (a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF)
                                 : (a == 64'h8000_0000_0000_0000 && b == '1);
         if (!z && !o) begin
            if (w32 && !n[3]) begin
               t32 = n[1] ? (a[31:0] % b[31:0]) : (a[31:0] / b[31:0]);
               r   = {32'b0, t32};
            end else if (w32) begin
               sa = a[31:0]; sb = b[31:0];
               t32 = n[1] ? (sa % sb) : (sa / sb);
               r   = {32'b0, t32};
            end else if (!n[3]) begin
               r = n[1] ? (a % b) : (a / b);
            end else begin
               la = a; lb = b;
               r = n[1] ? (la % lb) : (la / lb);
            end
         end
      end
      return {il, z, o, r};
   endfunction

   task automatic run_op(input string tag, input logic [7:0] op, input logic [63:0] a,
                         input logic [63:0] s, input logic [31:0] im);
      logic [63:0] bsel, exp_r;
      logic        il, z, o;
      logic [66:0] m;
      int          lat, exp_lat;
      bsel = op[3] ? s : {{32{im[31]}}, im};
      m = model(op, a, bsel);
      {il, z, o} = m[66:64];
      if (il || z || o) begin
         exp_r = last_res; exp_lat = 1;
      end else begin
         exp_r = m[63:0];
         exp_lat = (op[7:4] inside {4'h4, 4'h6, 4'hC, 4'hE}) ? 33 :
                   (op[7:4] inside {4'h5, 4'h7, 4'hD, 4'hF}) ? 65 : 1;
      end
      @(negedge clk);
      opcode = op; dst_opnd = a; src_opnd = s; imm_opnd = im; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      chk({tag, " R10 latency"}, 64'(lat), 64'(exp_lat));
      chk({tag, " result"}, result, exp_r);
      chk({tag, " R10 flags"}, {61'b0, illegal, div_zero, div_ovf}, {61'b0, il, z, o});
      last_res = exp_r;
      @(negedge clk);
      chk({tag, " R10 done pulse"}, {63'b0, done}, 64'b0);
   endtask

   task automatic t_reset;
      chk("R12 reset result", result, 64'b0);
      chk("R12 reset strobes", {60'b0, done, div_zero, div_ovf, illegal}, 64'b0);
   endtask

   task automatic t_high_mul;
      run_op("R2 umulh ones", 8'h3E, '1, '1, 32'h0);
      run_op("R2 R1 umulh imm", 8'h36, 64'h1_0000_0000, 64'h5, 32'h8000_0000);
      run_op("R2 smulh min*2", 8'hBE, 64'h8000_0000_0000_0000, 64'd2, 32'h0);
      run_op("R2 smulh -3*5", 8'hBE, -64'sd3, 64'd5, 32'h0);
      run_op("R2 smulh max*max", 8'hBE, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 32'h0);
      run_op("R2 R1 smulh imm neg", 8'hB6, 64'h1234_5678_9ABC_DEF0, 64'h0, 32'hFFFF_FFF0);
   endtask

   task automatic t_low_mul;
      run_op("R3 R4 lmul32", 8'h8E, 64'hDEAD_BEEF_1234_5678, 64'hFFFF_0000_0000_0003, 32'h0);
      run_op("R3 lmul64", 8'h9E, 64'hDEAD_BEEF_1234_5678, 64'hFFFF_0000_0000_0003, 32'h0);
      run_op("R3 R1 lmul32 imm", 8'h86, 64'h0000_0001_0000_0007, 64'h0, 32'hFFFF_FFFF);
      run_op("R3 lmul64 neg", 8'h9E, -64'sd9, 64'd11, 32'h0);
   endtask

   task automatic t_unsigned_div;
      run_op("R5 R4 udiv32", 8'h4E, 64'hFFFF_FFFF_FFFF_FFF0, 64'hABCD_0000_0000_0007, 32'h0);
      run_op("R5 udiv64", 8'h5E, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 32'h0);
      run_op("R5 R1 urem32 imm", 8'h66, 64'h0000_0000_0000_03E9, 64'h0, 32'd10);
      run_op("R5 urem64", 8'h7E, 64'h8000_0000_0000_0001, 64'h1_0000_0001, 32'h0);
      run_op("R5 udiv64 small", 8'h5E, 64'd5, 64'd9, 32'h0);
   endtask

   task automatic t_signed_div;
      run_op("R6 R4 sdiv32", 8'hCE, 64'h0000_0000_FFFF_FFF9, 64'd2, 32'h0);
      run_op("R6 sdiv64", 8'hDE, -64'sd7, 64'd2, 32'h0);
      run_op("R6 srem32", 8'hEE, 64'h0000_0000_FFFF_FFF9, 64'd2, 32'h0);
      run_op("R6 srem64", 8'hFE, 64'd7, -64'sd2, 32'h0);
      run_op("R6 R1 sdiv64 imm", 8'hD6, 64'd100, 64'h0, 32'hFFFF_FFF9);
      run_op("R6 R1 srem64 imm", 8'hF6, -64'sd100, 64'h0, 32'd7);
      run_op("R6 sdiv32 min by 1", 8'hCE, 64'h0000_0000_8000_0000, 64'd1, 32'h0);
      run_op("R6 sdiv64 min by low ones", 8'hDE, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF, 32'h0);
   endtask

   task automatic t_zero_div;
      run_op("R7 udiv64 zero", 8'h5E, 64'd77, 64'd0, 32'h0);
      run_op("R7 udiv32 imm zero", 8'h46, 64'd77, 64'h0, 32'h0);
      run_op("R7 R4 udiv32 low zero", 8'h4E, 64'd77, 64'h1_0000_0000, 32'h0);
      run_op("R7 srem32 zero", 8'hEE, 64'd77, 64'd0, 32'h0);
   endtask

   task automatic t_overflow;
      run_op("R8 sdiv64 min/-1", 8'hDE, 64'h8000_0000_0000_0000, '1, 32'h0);
      run_op("R8 sdiv32 imm min/-1", 8'hC6, 64'h0000_0000_8000_0000, 64'h0, 32'hFFFF_FFFF);
      run_op("R8 srem64 min/-1", 8'hFE, 64'h8000_0000_0000_0000, '1, 32'h0);
   endtask

   task automatic t_illegal;
      run_op("R9 nib2", 8'h2E, 64'd3, 64'd4, 32'h0);
      run_op("R9 R1 low bits", 8'h37, 64'd3, 64'd4, 32'h0);
      run_op("R9 nibA", 8'hAE, 64'd3, 64'd4, 32'h0);
      run_op("R9 R1 low bits 0x3F", 8'h3F, 64'd3, 64'd4, 32'h0);
   endtask

   task automatic t_busy_ignore;
      int lat;
      int extra;
      @(negedge clk);
      opcode = 8'h5E; dst_opnd = 64'd1000; src_opnd = 64'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      repeat (3) begin @(negedge clk); lat++; end
      opcode = 8'h9E; dst_opnd = 64'd3; src_opnd = 64'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0; lat++;
      while (!done && lat < 200) begin @(negedge clk); lat++; end
      chk("R11 R10 busy latency", 64'(lat), 64'd65);
      chk("R11 busy result", result, 64'd142);
      extra = 0;
      repeat (4) begin @(negedge clk); if (done) extra++; end
      chk("R11 no late done", 64'(extra), 64'd0);
      chk("R11 result kept", result, 64'd142);
      last_res = 64'd142;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_high_mul();
      t_low_mul();
      t_unsigned_div();
      t_signed_div();
      t_zero_div();
      t_overflow();
      t_illegal();
      t_busy_ignore();
      run_op("R5 after busy", 8'h7E, 64'd1000, 64'd7, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL R10 watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule